// File: doc/BRIEF.md
# Mixed-Width True Dual-Port RAM

This block holds 4096 bits. Two ports, A and B, can each read and write them. Each port has its own clock, reset, enable, write-enable, address and data. A parameter sets each port's data width to 1, 2, 4, 8 or 16 bits, and the address width of that port follows from it. Both ports see the same bit array. A word written through a port of one width can therefore be read back through the other port at a different width, for example to convert a byte stream into 2-bit symbols.

Reads are synchronous. A read or write on a port updates that port's output register on the next rising edge of the port's own clock, and the output holds between such edges. A write also returns the contents the word had before the write. The contents can be preset through a parameter, so the block can serve as a ROM.

Each port decodes its request into one of three named operations, which act as its states:

- PORT_HOLD: the enable is low.
- PORT_READ: the enable is high and the write-enable is low.
- PORT_WRITE: the enable is high and the write-enable is high.

The operation chosen at a clock edge selects the next value of the output register and of the storage.

Storage is split into two banks, one written by each port. The value of a stored bit is the XOR of the two banks. Each bank therefore has a single clock, and a port can write without arbitrating against the other port.

Top module: `mixwidth_dpram`

## Requirements
- R1: Each of `WIDTH_A` and `WIDTH_B` must be one of 1, 2, 4, 8 or 16. A port of width W has log2(4096/W) address bits, which gives the shapes 4096x1, 2048x2, 1024x4, 512x8 and 256x16.
- R2: A port of width W at address a covers array bits a*W to a*W+W-1. Data bit 0 maps to array bit a*W.
- R3: Data written through a port can be read back through the same port at the same address, for both A and B.
- R4: Data written through one port can be read through the other port at that port's own width, in both directions.
- R5: A port's output register changes only on a rising edge of that port's own clock, and only in the cycle after an access with the enable high. A read does not change the stored contents.
- R6: During a write (PORT_WRITE), the output register loads the contents the addressed word had before the write.
- R7: While a port's enable is low (PORT_HOLD), its output holds and its write-enable has no effect on the stored contents.
- R8: While a port's reset is low, that port's output reads zero. After both resets, array bit i equals bit i of the parameter `INIT`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| en_a | input | 1 | Port A access enable |
| we_a | input | 1 | Port A write enable (1 = write) |
| addr_a | input | log2(4096/WIDTH_A) | Port A word address |
| wdata_a | input | WIDTH_A | Port A write data |
| rdata_a | output | WIDTH_A | Port A registered read data |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| en_b | input | 1 | Port B access enable |
| we_b | input | 1 | Port B write enable (1 = write) |
| addr_b | input | log2(4096/WIDTH_B) | Port B word address |
| wdata_b | input | WIDTH_B | Port B write data |
| rdata_b | output | WIDTH_B | Port B registered read data |

## Verification
The bench runs the two ports at widths of 8 and 2 bits on clocks that are out of phase.

- Reads of the preset contents separate a correct `INIT` mapping from a reversed or offset one.
- A byte written on port A and then read as four 2-bit words on port B exposes any error in the bit ordering or address scaling.
- Writing 2-bit words on port B and reading them as a byte on port A tests the reverse direction.
- Writes with the enable low, and output samples taken just before each edge, separate a true hold and registered behaviour from a transparent output.
- Seeded random mixes of reads, writes and idle cycles on both ports, compared against a bench bit-array model, cover the remaining address and data combinations.

// File: rtl/mwdp_pkg.sv
package mwdp_pkg;

    localparam int unsigned MEM_BITS = 4096;
    localparam int unsigned MEM_AW   = $clog2(MEM_BITS);

    typedef enum logic [1:0] {
        PORT_HOLD  = 2'd0,
        PORT_READ  = 2'd1,
        PORT_WRITE = 2'd2
    } port_op_e;

    function automatic int unsigned addr_bits(input int unsigned w);
        return $clog2(MEM_BITS / w);
    endfunction

    function automatic bit legal_width(input int unsigned w);
        return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16);
    endfunction

endpackage

// File: rtl/mwdp_port.sv
module mwdp_port
    import mwdp_pkg::*;
#(
    parameter int unsigned W = 8,
    parameter logic [MEM_BITS-1:0] BANK_INIT = '0,
    localparam int unsigned AW = addr_bits(W),
    localparam int unsigned SH = $clog2(W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                we,
    input  logic [AW-1:0]       addr,
    input  logic [W-1:0]        wdata,
    input  logic [MEM_BITS-1:0] peer_bank,
    output logic [MEM_BITS-1:0] own_bank,
    output logic [W-1:0]        rdata
);

    port_op_e          op;
    logic [MEM_AW-1:0] base;
    logic [W-1:0]      cur_word;

    initial begin
        assert_width_legal_R1: assert (legal_width(W))
            else $error("port width %0d not allowed", W);
    end

    // decode the request into the port operation
    always_comb begin
        if (!en)     op = PORT_HOLD;
        else if (we) op = PORT_WRITE;
        else         op = PORT_READ;
    end

    // word at address a starts at bit a*W (R2)
    assign base     = MEM_AW'(addr) << SH;
    assign cur_word = own_bank[base +: W] ^ peer_bank[base +: W];

    // storage bank written by this port only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_bank <= BANK_INIT;
        end else begin
            unique case (op)
                PORT_WRITE: own_bank[base +: W] <= wdata ^ peer_bank[base +: W];
                PORT_READ, PORT_HOLD: ;
                default: ;
            endcase
        end
    end

    // output register: old contents on read and write (R6)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            unique case (op)
                PORT_READ, PORT_WRITE: rdata <= cur_word;
                PORT_HOLD: ;
                default: ;
            endcase
        end
    end

    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(rdata));

    assert_no_write_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(own_bank));

    assert_read_no_modify_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !we) |=> $stable(own_bank));

    assert_reset_zero_R8: assert property (@(posedge clk)
        !rst_n |-> (rdata == '0));

endmodule

// File: rtl/mixwidth_dpram.sv
module mixwidth_dpram
    import mwdp_pkg::*;
#(
    parameter int unsigned WIDTH_A = 8,
    parameter int unsigned WIDTH_B = 2,
    parameter logic [MEM_BITS-1:0] INIT = '0,
    localparam int unsigned AW_A = addr_bits(WIDTH_A),
    localparam int unsigned AW_B = addr_bits(WIDTH_B)
) (
    input  logic               clk_a,
    input  logic               rst_a_n,
    input  logic               en_a,
    input  logic               we_a,
    input  logic [AW_A-1:0]    addr_a,
    input  logic [WIDTH_A-1:0] wdata_a,
    output logic [WIDTH_A-1:0] rdata_a,
    input  logic               clk_b,
    input  logic               rst_b_n,
    input  logic               en_b,
    input  logic               we_b,
    input  logic [AW_B-1:0]    addr_b,
    input  logic [WIDTH_B-1:0] wdata_b,
    output logic [WIDTH_B-1:0] rdata_b
);

    logic [MEM_BITS-1:0] bank_a;
    logic [MEM_BITS-1:0] bank_b;

    // stored bit = bank_a ^ bank_b; preset lives in bank A
    mwdp_port #(.W(WIDTH_A), .BANK_INIT(INIT)) u_port_a (
        .clk       (clk_a),
        .rst_n     (rst_a_n),
        .en        (en_a),
        .we        (we_a),
        .addr      (addr_a),
        .wdata     (wdata_a),
        .peer_bank (bank_b),
        .own_bank  (bank_a),
        .rdata     (rdata_a)
    );

    mwdp_port #(.W(WIDTH_B), .BANK_INIT('0)) u_port_b (
        .clk       (clk_b),
        .rst_n     (rst_b_n),
        .en        (en_b),
        .we        (we_b),
        .addr      (addr_b),
        .wdata     (wdata_b),
        .peer_bank (bank_a),
        .own_bank  (bank_b),
        .rdata     (rdata_b)
    );

endmodule

// File: tb/mixwidth_dpram_tb.sv
`timescale 1ns/1ps
module mixwidth_dpram_tb;

    localparam int WA  = 8;
    localparam int WB  = 2;
    localparam int AWA = 9;
    localparam int AWB = 11;

    function automatic logic [4095:0] make_init();
        logic [4095:0] v;
        for (int i = 0; i < 4096; i++) v[i] = ((i * 37) ^ (i >> 3)) & 1;
        return v;
    endfunction

    localparam logic [4095:0] TB_INIT = make_init();

    logic clk_a = 0, clk_b = 0;
    logic rst_a_n, rst_b_n;
    logic en_a = 0, we_a = 0, en_b = 0, we_b = 0;
    logic [AWA-1:0] addr_a = '0;
    logic [AWB-1:0] addr_b = '0;
    logic [WA-1:0]  wdata_a = '0, rdata_a;
    logic [WB-1:0]  wdata_b = '0, rdata_b;

    logic [4095:0] model;
    logic [WA-1:0] exp_a;
    logic [WB-1:0] exp_b;
    int checks = 0, errors = 0;

    always #5 clk_a = ~clk_a;
    initial begin
        #2.5;
        forever #5 clk_b = ~clk_b;
    end

    mixwidth_dpram #(.WIDTH_A(WA), .WIDTH_B(WB), .INIT(TB_INIT)) u_dut (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .en_a(en_a), .we_a(we_a),
        .addr_a(addr_a), .wdata_a(wdata_a), .rdata_a(rdata_a),
        .clk_b(clk_b), .rst_b_n(rst_b_n), .en_b(en_b), .we_b(we_b),
        .addr_b(addr_b), .wdata_b(wdata_b), .rdata_b(rdata_b)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // one access on port A; checks the pre-edge hold (R5) and the result
    task automatic op_a(input bit en, input bit we, input logic [AWA-1:0] a,
                        input logic [WA-1:0] d, input string req);
        @(negedge clk_a);
        en_a = en; we_a = we; addr_a = a; wdata_a = d;
        #3;
        chk("R5 port A no change before edge", 16'(rdata_a), 16'(exp_a));
        if (en) begin
            exp_a = model[int'(a)*WA +: WA];
            if (we) model[int'(a)*WA +: WA] = d;
        end
        @(posedge clk_a); #1;
        chk(req, 16'(rdata_a), 16'(exp_a));
        en_a = 0; we_a = 0;
    endtask

    task automatic op_b(input bit en, input bit we, input logic [AWB-1:0] a,
                        input logic [WB-1:0] d, input string req);
        @(negedge clk_b);
        en_b = en; we_b = we; addr_b = a; wdata_b = d;
        #3;
        chk("R5 port B no change before edge", 16'(rdata_b), 16'(exp_b));
        if (en) begin
            exp_b = model[int'(a)*WB +: WB];
            if (we) model[int'(a)*WB +: WB] = d;
        end
        @(posedge clk_b); #1;
        chk(req, 16'(rdata_b), 16'(exp_b));
        en_b = 0; we_b = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        model = TB_INIT;
        exp_a = '0; exp_b = '0;
        rst_a_n = 0; rst_b_n = 0;
        repeat (3) @(posedge clk_a);
        #1;
        chk("R8 port A zero in reset", 16'(rdata_a), 16'h0);
        chk("R8 port B zero in reset", 16'(rdata_b), 16'h0);
        @(negedge clk_a); rst_a_n = 1; rst_b_n = 1;

        // preset contents (R8), bit mapping through both widths (R2)
        op_a(1, 0, 9'd0,   '0, "R8 port A reads INIT addr 0");
        op_a(1, 0, 9'd511, '0, "R8 port A reads INIT last addr");
        op_b(1, 0, 11'd5,  '0, "R8 port B reads INIT addr 5");
        chk("R8 INIT bits 0..7 explicit", 16'(model[7:0]), 16'(TB_INIT[7:0]));

        // A writes a byte, B reads it as four 2-bit words (R4, R2)
        op_a(1, 1, 9'd3, 8'hA5, "R6 port A write returns old word");
        op_a(1, 0, 9'd3, '0, "R3 port A readback");
        chk("R3 port A readback explicit", 16'(rdata_a), 16'h00A5);
        op_b(1, 0, 11'd12, '0, "R4 A to B addr 12");
        chk("R2 bits 24..25 explicit", 16'(rdata_b), 16'h1);
        op_b(1, 0, 11'd14, '0, "R4 A to B addr 14");
        chk("R2 bits 28..29 explicit", 16'(rdata_b), 16'h2);

        // B writes, A reads as a byte (R4, R2)
        op_a(1, 1, 9'd4, 8'h00, "R6 port A write old word");
        op_b(1, 1, 11'd17, 2'b11, "R6 port B write returns old word");
        op_b(1, 0, 11'd17, '0, "R3 port B readback");
        op_a(1, 0, 9'd4, '0, "R4 B to A addr 4");
        chk("R2 bits 34..35 explicit", 16'(rdata_a), 16'h000C);

        // read-before-write explicit (R6)
        op_a(1, 1, 9'd4, 8'h3C, "R6 port A overwrite");
        chk("R6 old value explicit", 16'(rdata_a), 16'h000C);

        // enable low: output holds, write ignored (R7)
        op_a(0, 1, 9'd4, 8'hFF, "R7 port A hold with we high");
        op_a(1, 0, 9'd4, '0, "R7 port A word unchanged");
        chk("R7 word unchanged explicit", 16'(rdata_a), 16'h003C);
        op_b(0, 1, 11'd16, 2'b11, "R7 port B hold with we high");
        op_b(1, 0, 11'd16, '0, "R7 port B word unchanged");
        chk("R7 port B word explicit", 16'(rdata_b), 16'h0);

        // random mix on both ports against the model (R3 R4 R5 R6 R7)
        for (int i = 0; i < 800; i++) begin
            bit en, we;
            en = ($urandom % 5) != 0;
            we = $urandom % 2;
            if ($urandom % 2)
                op_a(en, we, AWA'($urandom), WA'($urandom), "R4 random port A");
            else
                op_b(en, we, AWB'($urandom), WB'($urandom), "R4 random port B");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule